// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block sits beside the shift logic of a serial NOR flash slave and decides which instructions may change the device. It samples chip select, serial clock and serial data with the system clock, counts the serial clock pulses of each transaction, and keeps the opcode, the second byte and the 24-bit address. When chip select rises it judges the finished instruction against the write-enable latch, the block-protect level, the status-register lock taken with the write-protect pin, the busy flag, deep power-down and a power-on inhibit timer. It fires a one-cycle accept strobe for a program, an erase or a status write.

The array stub answers each accepted operation with a one-cycle done pulse. That pulse ends the busy phase, clears the write-enable latch and, for a status write, commits the new protection bits. A separate combinational port reports whether any address falls inside the region that the current block-protect level makes read-only. No interface carries a data stream, so there is no valid/ready handshake and no back-pressure. The strobes are single-cycle events and the stub must take them when they occur.

Top module: `flash_guard`

## Requirements
- R1: A status write (0x01), page program (0x02), sector erase (0x20), block erase (0xD8) or chip erase (0x60 or 0xC7) is discarded unless its serial clock count is a whole multiple of eight. Length floors also apply: status write at least 16, sector and block erase at least 32, program at least 40, chip erase at least 8.
- R2: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Each takes effect once at least 8 clocks are seen. Any modifying instruction that arrives while the latch is clear is ignored.
- R3: A done pulse while busy clears both busy and the write-enable latch. For a status write, the same pulse loads the block-protect level from data bits 4:2 and the lock bit from data bit 7.
- R4: A block-protect level of 0 protects nothing. Levels 1, 2 and 3 protect the top 1, 2 and 4 of the eight 64 KB blocks (block = address bits 18:16), and levels 4 to 7 protect all eight. A program or erase aimed at a protected block is rejected, and a chip erase is rejected at any nonzero level. `chk_hit` reports protection for `chk_addr`.
- R5: A status write is rejected while `wp_n` is low and the lock bit is set.
- R6: Opcode 0xB9 enters deep power-down. While in it, every instruction except 0xAB is ignored, and 0xAB with at least 8 clocks returns to normal operation.
- R7: No modifying instruction is accepted until INHIBIT clock cycles have passed since reset. The write-enable instructions are not held back by this timer.
- R8: While busy, every instruction is ignored. An accepted instruction sets busy in the same cycle as its strobe.
- R9: Status layout: bit0 busy, bit1 write-enable latch, bits 4:2 block-protect level, bit7 lock. Bits 5 and 6 are always zero. Reset value is 0x00.
- R10: An accept strobe lasts one clock and appears at the second rising clock edge after `cs_n` rises. At that time `cmd_addr` holds the 24 bits that followed the opcode. `ers_kind` is 0 for sector, 1 for block and 2 for chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than four times the serial clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, sampled on its rising edge (mode 0) |
| mosi | input | 1 | Serial data in, most significant bit first |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | One-cycle completion pulse from the array stub |
| chk_addr | input | ADDR_W | Address to test against the protected region |
| chk_hit | output | 1 | High when chk_addr lies in a read-only block |
| sreg | output | 8 | Status register |
| in_dp | output | 1 | Deep power-down is active |
| pgm_go | output | 1 | Page program accepted |
| ers_go | output | 1 | Erase accepted |
| ers_kind | output | 2 | Erase size for ers_go |
| wsr_go | output | 1 | Status write accepted |
| cmd_addr | output | ADDR_W | Address of the instruction being judged |

## Verification
Every piece of state shows up on `sreg` or `in_dp` within two clock edges of the chip-select rise that changed it. A stale write-enable latch, a wrong protect level or a busy flag that does not clear therefore shows on the very next comparison. Faults that leave the status unchanged show up at the next instruction that depends on that state. A strobe that fires wrongly or stays silent appears exactly at the second edge after chip select rises. A wrong protection map shows at once on `chk_hit`, and it also shows on the next program or erase as a strobe that does or does not fire.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_BE   = 8'hD8;
  localparam logic [7:0] OP_CE0  = 8'h60;
  localparam logic [7:0] OP_CE1  = 8'hC7;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_RES  = 8'hAB;

  typedef enum logic [1:0] {
    ERS_SECTOR = 2'd0,
    ERS_BLOCK  = 2'd1,
    ERS_CHIP   = 2'd2
  } ers_kind_e;
endpackage

// File: rtl/fg_spi_rx.sv
module fg_spi_rx #(
  parameter int ADDR_W = 24,
  parameter int CW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              end_pls,
  output logic [7:0]        op,
  output logic [7:0]        dat,
  output logic [ADDR_W-1:0] addr,
  output logic [CW-1:0]     nbits,
  output logic              aligned
);
  localparam int HDR = 8 + ADDR_W;
  localparam int SAT = HDR + 8;
  localparam logic [CW-1:0] K_SAT  = CW'(SAT);
  localparam logic [CW-1:0] K_HDR  = CW'(HDR);
  localparam logic [CW-1:0] K_OP7  = CW'(7);
  localparam logic [CW-1:0] K_DAT7 = CW'(15);

  logic s_cs, s_sck, s_mosi, p_cs, p_sck;
  logic [2:0]     phase;
  logic [HDR-1:0] sh;
  logic           rise;

  assign rise    = s_sck & ~p_sck & ~s_cs;
  assign end_pls = s_cs & ~p_cs;
  assign aligned = (phase == 3'd0);
  assign addr    = sh[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cs <= 1'b1; p_cs <= 1'b1;
      s_sck <= 1'b0; p_sck <= 1'b0; s_mosi <= 1'b0;
      phase <= '0; nbits <= '0; sh <= '0;
      op <= '0; dat <= '0;
    end else begin
      s_cs <= cs_n; p_cs <= s_cs;
      s_sck <= sck; p_sck <= s_sck; s_mosi <= mosi;
      if (s_cs) begin
        nbits <= '0;
        phase <= '0;
      end else if (rise) begin
        phase <= phase + 3'd1;
        if (nbits != K_SAT) nbits <= nbits + CW'(1);
        if (nbits < K_HDR)  sh <= {sh[HDR-2:0], s_mosi};
        if (nbits == K_OP7)  op  <= {sh[6:0], s_mosi};
        if (nbits == K_DAT7) dat <= {sh[6:0], s_mosi};
      end
    end
  end
endmodule

// File: rtl/fg_blk_prot.sv
module fg_blk_prot #(
  parameter int BLK_W = 3
) (
  input  logic [2:0]       bp,
  input  logic [BLK_W-1:0] blk,
  output logic             hit
);
  localparam int NBLK = 1 << BLK_W;
  localparam logic [BLK_W:0] K_ALL = (BLK_W+1)'(NBLK);

  logic [BLK_W:0] span;

  always_comb begin
    if (bp == 3'd0)
      span = '0;
    else if (int'(bp) - 1 >= BLK_W)
      span = K_ALL;
    else
      span = {{BLK_W{1'b0}}, 1'b1} << (bp - 3'd1);
  end

  assign hit = (({1'b0, blk} + span) >= K_ALL);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int BLK_W   = 3,
  parameter int BLK_LSB = 16,
  parameter int INHIBIT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              wp_n,
  input  logic              op_done,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_hit,
  output logic [7:0]        sreg,
  output logic              in_dp,
  output logic              pgm_go,
  output logic              ers_go,
  output logic [1:0]        ers_kind,
  output logic              wsr_go,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int HDR = 8 + ADDR_W;
  localparam int CW  = $clog2(HDR + 9);
  localparam int TW  = $clog2(INHIBIT + 1);
  localparam logic [CW-1:0] N_OP  = CW'(8);
  localparam logic [CW-1:0] N_SR  = CW'(16);
  localparam logic [CW-1:0] N_ADR = CW'(HDR);
  localparam logic [CW-1:0] N_PP  = CW'(HDR + 8);
  localparam logic [TW-1:0] T_END = TW'(INHIBIT);

  logic              end_pls, aligned;
  logic [7:0]        op, dat;
  logic [ADDR_W-1:0] rx_addr;
  logic [CW-1:0]     nbits;
  logic              cmd_hit;

  logic              wip_q, wel_q, srwd_q, dp_q, pend_sr_q, pend_srwd_q;
  logic [2:0]        bp_q, pend_bp_q;
  logic [TW-1:0]     tmr;
  logic              ready, mod_ok, sr_lock;
  logic              unused_bits;

  fg_spi_rx #(.ADDR_W(ADDR_W), .CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .end_pls(end_pls), .op(op), .dat(dat), .addr(rx_addr),
    .nbits(nbits), .aligned(aligned)
  );

  fg_blk_prot #(.BLK_W(BLK_W)) u_cmd_map (
    .bp(bp_q), .blk(rx_addr[BLK_LSB +: BLK_W]), .hit(cmd_hit)
  );

  fg_blk_prot #(.BLK_W(BLK_W)) u_chk_map (
    .bp(bp_q), .blk(chk_addr[BLK_LSB +: BLK_W]), .hit(chk_hit)
  );

  assign unused_bits = ^{chk_addr[BLK_LSB-1:0], chk_addr[ADDR_W-1:BLK_LSB+BLK_W],
                         dat[6:5], dat[1:0]};

  assign ready    = (tmr == T_END);
  assign mod_ok   = wel_q && ready && aligned;
  assign sr_lock  = !wp_n && srwd_q;
  assign sreg     = {srwd_q, 2'b00, bp_q, wel_q, wip_q};
  assign in_dp    = dp_q;
  assign cmd_addr = rx_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr <= '0;
    else if (tmr != T_END) tmr <= tmr + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_q <= 1'b0; wel_q <= 1'b0; srwd_q <= 1'b0; dp_q <= 1'b0;
      bp_q <= '0; pend_sr_q <= 1'b0; pend_bp_q <= '0; pend_srwd_q <= 1'b0;
      pgm_go <= 1'b0; ers_go <= 1'b0; wsr_go <= 1'b0; ers_kind <= ERS_SECTOR;
    end else begin
      pgm_go <= 1'b0;
      ers_go <= 1'b0;
      wsr_go <= 1'b0;
      if (op_done && wip_q) begin
        wip_q <= 1'b0;
        wel_q <= 1'b0;
        if (pend_sr_q) begin
          bp_q   <= pend_bp_q;
          srwd_q <= pend_srwd_q;
        end
      end
      if (end_pls) begin
        if (dp_q) begin
          if (op == OP_RES && nbits >= N_OP) dp_q <= 1'b0;
        end else if (!wip_q) begin
          case (op)
            OP_WREN: if (nbits >= N_OP) wel_q <= 1'b1;
            OP_WRDI: if (nbits >= N_OP) wel_q <= 1'b0;
            OP_DP:   if (nbits >= N_OP) dp_q <= 1'b1;
            OP_WRSR: if (mod_ok && nbits >= N_SR && !sr_lock) begin
              wsr_go <= 1'b1; wip_q <= 1'b1; pend_sr_q <= 1'b1;
              pend_bp_q <= dat[4:2]; pend_srwd_q <= dat[7];
            end
            OP_PP: if (mod_ok && nbits >= N_PP && !cmd_hit) begin
              pgm_go <= 1'b1; wip_q <= 1'b1; pend_sr_q <= 1'b0;
            end
            OP_SE, OP_BE: if (mod_ok && nbits >= N_ADR && !cmd_hit) begin
              ers_go <= 1'b1; wip_q <= 1'b1; pend_sr_q <= 1'b0;
              ers_kind <= (op == OP_SE) ? ERS_SECTOR : ERS_BLOCK;
            end
            OP_CE0, OP_CE1: if (mod_ok && nbits >= N_OP && bp_q == 3'd0) begin
              ers_go <= 1'b1; wip_q <= 1'b1; pend_sr_q <= 1'b0;
              ers_kind <= ERS_CHIP;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int INHIBIT = 4096
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       op_done,
  input logic [7:0] sreg,
  input logic       in_dp,
  input logic       pgm_go,
  input logic       ers_go,
  input logic [1:0] ers_kind,
  input logic       wsr_go
);
  localparam int TW = $clog2(INHIBIT + 1);
  logic [TW-1:0] since_rst;
  logic          any_go;

  assign any_go = pgm_go || ers_go || wsr_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != TW'(INHIBIT)) since_rst <= since_rst + TW'(1);
  end

  p_go_needs_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_go |-> $past(sreg[1]));
  p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_done) && $past(sreg[0])) |-> (sreg[1:0] == 2'b00));
  p_chip_unprotected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_go && ers_kind == 2'd2) |-> ($past(sreg[4:2]) == 3'b000));
  p_hw_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wsr_go |-> !(!$past(wp_n) && $past(sreg[7])));
  p_sleep_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_dp |-> !any_go);
  p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_go |-> (since_rst == TW'(INHIBIT)));
  p_busy_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_go |-> (sreg[0] && !$past(sreg[0])));
  p_zero_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sreg[6:5] == 2'b00);
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_go, ers_go, wsr_go}));
  p_strobe_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    any_go |=> !any_go);
endmodule

bind flash_guard flash_guard_chk #(.INHIBIT(INHIBIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .op_done(op_done), .sreg(sreg),
  .in_dp(in_dp), .pgm_go(pgm_go), .ers_go(ers_go), .ers_kind(ers_kind),
  .wsr_go(wsr_go)
);

// File: tb/flash_guard_test.sv
module flash_guard_test;
  localparam int INH = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1, op_done = 1'b0;
  logic [23:0] chk_addr = '0;
  logic        chk_hit, in_dp, pgm_go, ers_go, wsr_go;
  logic [7:0]  sreg;
  logic [1:0]  ers_kind;
  logic [23:0] cmd_addr;

  flash_guard #(.INHIBIT(INH)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .op_done(op_done), .chk_addr(chk_addr), .chk_hit(chk_hit),
    .sreg(sreg), .in_dp(in_dp), .pgm_go(pgm_go), .ers_go(ers_go),
    .ers_kind(ers_kind), .wsr_go(wsr_go), .cmd_addr(cmd_addr)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit run = 0;
  string cur_req = "R9";

  // behavioural reference state
  bit m_wip, m_wel, m_srwd, m_dp, m_pend_sr, m_psrwd;
  int m_bp, m_pbp;
  bit e_pgm, e_ers, e_wsr;
  int e_kind;
  logic [23:0] e_addr;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_hit(input int bp, input int blk);
    int span;
    span = (bp == 0) ? 0 : (bp >= 4) ? 8 : (1 << (bp - 1));
    return blk >= 8 - span;
  endfunction

  always @(posedge clk) if (rst_n) cyc++;

  always @(negedge clk) begin
    if (run) begin
      check(sreg == {m_srwd, 2'b00, m_bp[2:0], m_wel, m_wip}, cur_req, "status",
            sreg, {m_srwd, 2'b00, m_bp[2:0], m_wel, m_wip});
      check(in_dp == m_dp, cur_req, "in_dp", in_dp, m_dp);
      check({pgm_go, ers_go, wsr_go} == {e_pgm, e_ers, e_wsr}, cur_req, "strobes",
            {pgm_go, ers_go, wsr_go}, {e_pgm, e_ers, e_wsr});
      if (e_ers) check(ers_kind == e_kind[1:0], cur_req, "ers_kind", ers_kind, e_kind);
      if (e_pgm || (e_ers && e_kind != 2))
        check(cmd_addr == e_addr, cur_req, "cmd_addr", cmd_addr, e_addr);
    end
  end

  // v is left aligned: first bit sent is v[47]
  task automatic spi(input logic [47:0] v, input int n);
    logic [7:0] op;
    bit al, rdy, prot, nwip, nwel, ndp;
    bit gp, ge, gw;
    int kd;
    op = v[47:40];
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = v[47-i]; sck = 1'b0;
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (2) @(negedge clk);
    end
    sck = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    al = (n % 8) == 0; rdy = cyc >= INH; prot = exp_hit(m_bp, int'(v[34:32]));
    nwip = m_wip; nwel = m_wel; ndp = m_dp; gp = 0; ge = 0; gw = 0; kd = 0;
    if (m_dp) begin
      if (op == 8'hAB && n >= 8) ndp = 0;
    end else if (!m_wip) begin
      if (op == 8'h06 && n >= 8) nwel = 1;
      else if (op == 8'h04 && n >= 8) nwel = 0;
      else if (op == 8'hB9 && n >= 8) ndp = 1;
      else if (m_wel && rdy && al) begin
        if (op == 8'h01 && n >= 16 && !(!wp_n && m_srwd)) begin
          gw = 1; m_pend_sr = 1; m_pbp = int'(v[36:34]); m_psrwd = v[39];
        end else if (op == 8'h02 && n >= 40 && !prot) gp = 1;
        else if ((op == 8'h20 || op == 8'hD8) && n >= 32 && !prot) begin
          ge = 1; kd = (op == 8'h20) ? 0 : 1;
        end else if ((op == 8'h60 || op == 8'hC7) && m_bp == 0) begin
          ge = 1; kd = 2;
        end
        if (gp || ge) m_pend_sr = 0;
        if (gp || ge || gw) nwip = 1;
      end
    end
    @(posedge clk); @(posedge clk);
    m_wip = nwip; m_wel = nwel; m_dp = ndp;
    e_pgm = gp; e_ers = ge; e_wsr = gw; e_kind = kd; e_addr = v[39:16];
    @(posedge clk);
    e_pgm = 0; e_ers = 0; e_wsr = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_op();
    @(negedge clk) op_done = 1'b1;
    @(posedge clk);
    if (m_wip) begin
      m_wip = 0; m_wel = 0;
      if (m_pend_sr) begin m_bp = m_pbp; m_srwd = m_psrwd; end
    end
    @(negedge clk) op_done = 1'b0;
  endtask

  task automatic set_sr(input logic [7:0] d);
    spi({8'h06, 40'h0}, 8);
    spi({8'h01, d, 32'h0}, 16);
    finish_op();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    run = 1;
    @(negedge clk);
    check(sreg == 8'h00, "R9", "reset status", sreg, 0);

    cur_req = "R7";                       // inhibit window: WREN works, WRSR not
    spi({8'h06, 40'h0}, 8);
    spi({8'h01, 8'h9C, 32'h0}, 16);
    check(cyc < INH, "R7", "test ran inside window", cyc, INH);
    while (cyc < INH + 10) @(negedge clk);

    cur_req = "R2";
    spi({8'h04, 40'h0}, 8);
    spi({8'h01, 8'h08, 32'h0}, 16);       // no latch -> ignored
    spi({8'h06, 40'h0}, 8);

    cur_req = "R1";
    spi({8'h01, 8'h08, 32'h0}, 15);
    spi({8'h01, 8'h08, 32'h0}, 17);

    cur_req = "R8";
    spi({8'h01, 8'h08, 32'h0}, 16);       // accepted, busy
    spi({8'h04, 40'h0}, 8);               // ignored while busy
    spi({8'hB9, 40'h0}, 8);
    cur_req = "R3";
    finish_op();
    check(sreg == 8'h08, "R3", "bp committed", sreg, 8'h08);

    cur_req = "R4";
    spi({8'h06, 40'h0}, 8);
    spi({8'h02, 24'h07_1200, 16'hA500}, 40);   // block 7 protected
    spi({8'h02, 24'h06_0000, 16'hA500}, 40);   // block 6 protected
    cur_req = "R10";
    spi({8'h02, 24'h02_3456, 16'hA500}, 40);   // accepted
    finish_op();
    cur_req = "R1";
    spi({8'h06, 40'h0}, 8);
    spi({8'h02, 24'h01_0010, 16'h5A5A}, 39);
    spi({8'h02, 24'h01_0010, 16'h5A5A}, 48);
    finish_op();
    cur_req = "R4";
    spi({8'h06, 40'h0}, 8);
    spi({8'hC7, 40'h0}, 8);                    // bp != 0

    cur_req = "R5";
    set_sr(8'h80);
    spi({8'h06, 40'h0}, 8);
    wp_n = 1'b0;
    spi({8'h01, 8'h1C, 32'h0}, 16);            // locked
    check(sreg[7] && sreg[1], "R5", "lock held, latch kept", sreg, 8'h82);
    wp_n = 1'b1;
    spi({8'h01, 8'h00, 32'h0}, 16);
    finish_op();

    cur_req = "R10";
    spi({8'h06, 40'h0}, 8);
    spi({8'h60, 40'h0}, 8);
    finish_op();
    spi({8'h06, 40'h0}, 8);
    spi({8'h20, 24'h07_F000, 16'h0}, 32);
    finish_op();
    spi({8'h06, 40'h0}, 8);
    spi({8'hD8, 24'h05_0000, 16'h0}, 32);
    finish_op();

    cur_req = "R6";
    spi({8'h06, 40'h0}, 8);
    spi({8'hB9, 40'h0}, 8);
    spi({8'h04, 40'h0}, 8);
    spi({8'h20, 24'h00_0000, 16'h0}, 32);
    check(in_dp && sreg[1], "R6", "sleep kept latch", {in_dp, sreg}, 9'h102);
    spi({8'hAB, 40'h0}, 8);
    spi({8'h20, 24'h00_0000, 16'h0}, 32);
    finish_op();

    cur_req = "R4";
    for (int bp = 0; bp < 8; bp++) begin
      set_sr(8'(bp << 2));
      for (int blk = 0; blk < 8; blk++) begin
        @(negedge clk) chk_addr = 24'((blk << 16) | 16'h1234);
        #1 check(chk_hit == exp_hit(bp, blk), "R4", "chk_hit", chk_hit, exp_hit(bp, blk));
      end
    end

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule